// File: doc/BRIEF.md
# Bit-Block Word Combiner

This block is the per-word data path of a bit-block transfer engine. For every destination word of a rectangle it receives the next source word and the current destination word from the fetch logic. It aligns the source to the destination with a barrel shift across two consecutive source words. It picks a pattern word from a 16-entry halftone store and blends the pattern with the source under a 2-bit selector. It then applies any of the 16 two-input boolean functions of source and destination. Last, it merges the result into the destination through an edge mask. The address loops and the bus master are outside the block. They present one word per step on `word_en` and take the finished word from `wr_data` one cycle later.

A small state machine follows the position inside the rectangle. Its states are `ST_IDLE`, `ST_PRIME` and `ST_WORD`:
- `ST_IDLE` waits for `go`. A `go` with non-zero word and line counts moves it to `ST_PRIME` when `fxsr` is set and to `ST_WORD` otherwise. The transition is *start*.
- `ST_PRIME` consumes one source word and writes nothing. A step moves it to `ST_WORD` (*primed*).
- `ST_WORD` produces one write per step. On the last word of a line it goes to `ST_PRIME` or stays in `ST_WORD` (*next line*). On the last line it goes to `ST_IDLE` (*done*).

The line number steps at the end of every line. It indexes the halftone store unless smudge mode takes the index from the source data.

Top module: `blt_word_combine`

## Requirements
- R1: The halftone store holds 16 words of 16 bits. All words are zero after reset. A write with `ht_we` high stores `ht_wdata` at `ht_addr`, and that word is used by any step from the next cycle on.
- R2: The halftone index is `line_num` when `smudge` is 0. When `smudge` is 1 it is bits 3:0 of the aligned source word.
- R3: The pattern operand follows `hop`: 0 gives all ones, 1 gives the halftone word, 2 gives the aligned source, and 3 gives the aligned source AND the halftone word.
- R4: Each result bit is a bit of `op`, selected by the pattern bit p and the destination bit d. The bit used is `op[0]` for p=1,d=1, `op[1]` for p=1,d=0, `op[2]` for p=0,d=1 and `op[3]` for p=0,d=0. For example, 0 gives zeros, 3 gives p, 6 gives XOR and 15 gives ones.
- R5: The aligned source is bits 15:0 of the 32-bit value {previous source word, current source word} shifted right by `skew`. The previous word is cleared by a start and is replaced by every consumed source word.
- R6: With `fxsr` set, every line begins with a priming step. That step consumes a source word (`src_take`=1) and produces no write.
- R7: With `nfsr` set, the last word of each line consumes no source word (`src_take`=0), and the current source word counts as zero.
- R8: The first word of a line, including the only word of a one-word line, uses `mask_first`. The last word of a line longer than one word uses `mask_last`, and every other word uses `mask_mid`. A mask bit of 1 takes the result and a 0 keeps the destination bit.
- R9: A start loads `line_num` from `line_init`. At the end of every line, including the final one, `line_num` steps by +1, or by -1 when `line_down` is 1, modulo 16.
- R10: A `go` in `ST_IDLE` with non-zero `x_words` and `y_lines` runs `y_lines` lines of `x_words` words each and then returns to idle with `busy` low. A `go` with either count zero is ignored.
- R11: `wr_valid` pulses, and `wr_data` holds the word, in the cycle after each step taken in `ST_WORD`. No other cycle writes, and `word_en` in idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ht_we | input | 1 | Halftone store write enable |
| ht_addr | input | 4 | Halftone store write index |
| ht_wdata | input | 16 | Halftone store write data |
| hop | input | 2 | Pattern operand selector |
| op | input | 4 | Boolean function code |
| skew | input | 4 | Source right-shift count |
| fxsr | input | 1 | Add a priming source read per line |
| nfsr | input | 1 | Skip the source read on the last word |
| smudge | input | 1 | Index the halftone store from the source data |
| line_init | input | 4 | Starting line number |
| line_down | input | 1 | Line number counts down |
| mask_first | input | 16 | Edge mask for the first word |
| mask_mid | input | 16 | Mask for the middle words |
| mask_last | input | 16 | Edge mask for the last word |
| x_words | input | 16 | Words per line |
| y_lines | input | 16 | Lines per rectangle |
| go | input | 1 | Start a rectangle |
| word_en | input | 1 | One step is presented this cycle |
| src_in | input | 16 | Source word for this step |
| dst_in | input | 16 | Destination word for this step |
| src_take | output | 1 | A step now consumes a source word |
| busy | output | 1 | A rectangle is in progress |
| line_num | output | 4 | Current line number |
| wr_valid | output | 1 | Result word valid |
| wr_data | output | 16 | Result word |

## Verification
The bench walks all 16 boolean codes with a source and destination pair that covers every bit combination. A wrong code-to-function map would corrupt at least one of them. It runs multi-word lines with three distinct masks and a one-word line. A design that picked the last mask for a single word, or swapped the keep sense, would return the wrong bits. It runs skewed lines with and without the priming read and the skipped final read, and checks `src_take` on every step. A missing prime, a stale previous word after a start or a fetched final word would show as shifted data. It also wraps the line number up past 15 and down past 0 and uses smudge indexing, where a design without modulo wrap or with the wrong index source would choose the wrong pattern word.

// File: rtl/blt_pkg.sv
package blt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRIME = 2'd1,
        ST_WORD  = 2'd2
    } blt_state_e;

    localparam logic [1:0] HOP_ONES = 2'd0;
    localparam logic [1:0] HOP_HT   = 2'd1;
    localparam logic [1:0] HOP_SRC  = 2'd2;
    localparam logic [1:0] HOP_AND  = 2'd3;
endpackage

// File: rtl/blt_halftone_ram.sv
module blt_halftone_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (we && waddr == IDX_W'(e)) begin
                mem[e] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

    AST_HT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && raddr == $past(waddr)) |-> rdata == $past(wdata)); // R1
endmodule

// File: rtl/blt_skew.sv
module blt_skew #(
    parameter int W = 16,
    localparam int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    prev,
    input  logic [W-1:0]    cur,
    input  logic [SH_W-1:0] amount,
    output logic [W-1:0]    aligned
);
    logic [2*W-1:0] joined;
    logic [2*W-1:0] shifted;

    assign joined  = {prev, cur};
    assign shifted = joined >> amount;
    assign aligned = shifted[W-1:0];
endmodule

// File: rtl/blt_combine_logic.sv
module blt_combine_logic
    import blt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   hop,
    input  logic [3:0]   op,
    input  logic [W-1:0] src,
    input  logic [W-1:0] ht,
    input  logic [W-1:0] dst,
    input  logic [W-1:0] mask,
    output logic [W-1:0] res
);
    logic [W-1:0] pat;
    logic [W-1:0] lop;

    always_comb begin
        unique case (hop)
            HOP_ONES: pat = '1;
            HOP_HT:   pat = ht;
            HOP_SRC:  pat = src;
            HOP_AND:  pat = src & ht;
            default:  pat = '1;
        endcase
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign lop[b] = op[{~pat[b], ~dst[b]}];
    end

    assign res = (lop & mask) | (dst & ~mask);
endmodule

// File: rtl/blt_word_combine.sv
module blt_word_combine
    import blt_pkg::*;
#(
    parameter int W        = 16,
    parameter int HT_DEPTH = 16,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(HT_DEPTH),
    localparam int SH_W    = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ht_we,
    input  logic [IDX_W-1:0] ht_addr,
    input  logic [W-1:0]     ht_wdata,
    input  logic [1:0]       hop,
    input  logic [3:0]       op,
    input  logic [SH_W-1:0]  skew,
    input  logic             fxsr,
    input  logic             nfsr,
    input  logic             smudge,
    input  logic [IDX_W-1:0] line_init,
    input  logic             line_down,
    input  logic [W-1:0]     mask_first,
    input  logic [W-1:0]     mask_mid,
    input  logic [W-1:0]     mask_last,
    input  logic [CNT_W-1:0] x_words,
    input  logic [CNT_W-1:0] y_lines,
    input  logic             go,
    input  logic             word_en,
    input  logic [W-1:0]     src_in,
    input  logic [W-1:0]     dst_in,
    output logic             src_take,
    output logic             busy,
    output logic [IDX_W-1:0] line_num,
    output logic             wr_valid,
    output logic [W-1:0]     wr_data
);
    blt_state_e       state_q, state_d;
    logic [CNT_W-1:0] widx_q, xw_q, yleft_q;
    logic [W-1:0]     prev_q;
    logic [IDX_W-1:0] line_q;
    logic             wr_valid_q;
    logic [W-1:0]     wr_data_q;

    logic             start, first_word, last_word, in_word;
    logic [W-1:0]     cur_src, aligned, ht_word, mask_sel, result;
    logic [IDX_W-1:0] ht_idx, line_next;

    assign start      = (state_q == ST_IDLE) && go && (x_words != '0) && (y_lines != '0);
    assign in_word    = (state_q == ST_WORD);
    assign first_word = (widx_q == '0);
    assign last_word  = (widx_q == xw_q - CNT_W'(1));
    assign src_take   = (state_q == ST_PRIME) || (in_word && !(last_word && nfsr));
    assign cur_src    = (in_word && src_take) ? src_in : '0;
    assign ht_idx     = smudge ? aligned[IDX_W-1:0] : line_q;
    assign line_next  = line_down ? line_q - IDX_W'(1) : line_q + IDX_W'(1);
    assign mask_sel   = first_word ? mask_first : (last_word ? mask_last : mask_mid);

    blt_skew #(.W(W)) u_skew (
        .prev    (prev_q),
        .cur     (cur_src),
        .amount  (skew),
        .aligned (aligned)
    );

    blt_halftone_ram #(.W(W), .DEPTH(HT_DEPTH)) u_ht (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ht_we),
        .waddr (ht_addr),
        .wdata (ht_wdata),
        .raddr (ht_idx),
        .rdata (ht_word)
    );

    blt_combine_logic #(.W(W)) u_logic (
        .hop  (hop),
        .op   (op),
        .src  (aligned),
        .ht   (ht_word),
        .dst  (dst_in),
        .mask (mask_sel),
        .res  (result)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = fxsr ? ST_PRIME : ST_WORD;
            ST_PRIME: if (word_en) state_d = ST_WORD;
            ST_WORD: begin
                if (word_en && last_word) begin
                    if (yleft_q == CNT_W'(1)) state_d = ST_IDLE;
                    else                     state_d = fxsr ? ST_PRIME : ST_WORD;
                end
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters, source history and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q     <= '0;
            xw_q       <= '0;
            yleft_q    <= '0;
            prev_q     <= '0;
            line_q     <= '0;
            wr_valid_q <= 1'b0;
            wr_data_q  <= '0;
        end else begin
            wr_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        xw_q    <= x_words;
                        yleft_q <= y_lines;
                        widx_q  <= '0;
                        prev_q  <= '0;
                        line_q  <= line_init;
                    end
                end
                ST_PRIME: begin
                    if (word_en) prev_q <= src_in;
                end
                ST_WORD: begin
                    if (word_en) begin
                        wr_valid_q <= 1'b1;
                        wr_data_q  <= result;
                        if (src_take) prev_q <= src_in;
                        if (last_word) begin
                            widx_q  <= '0;
                            yleft_q <= yleft_q - CNT_W'(1);
                            line_q  <= line_next;
                        end else begin
                            widx_q <= widx_q + CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign line_num = line_q;
    assign wr_valid = wr_valid_q;
    assign wr_data  = wr_data_q;

    AST_WR_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(state_q == ST_WORD && word_en)); // R11
    AST_PRIME_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_PRIME) |-> !wr_valid); // R6
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && line_num != $past(line_num)) |->
            (line_num == $past(line_num) + IDX_W'(1) || line_num == $past(line_num) - IDX_W'(1))); // R9
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy) |-> $past(word_en && last_word && yleft_q == CNT_W'(1))); // R10
    AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !src_take); // R10
endmodule

// File: tb/tb_blt_word_combine.sv
`timescale 1ns/100ps
module tb_blt_word_combine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ht_we = 1'b0;
    logic [3:0]  ht_addr = '0;
    logic [15:0] ht_wdata = '0;
    logic [1:0]  hop = 2'd2;
    logic [3:0]  op = 4'd3;
    logic [3:0]  skew = '0;
    logic        fxsr = 1'b0, nfsr = 1'b0, smudge = 1'b0, line_down = 1'b0;
    logic [3:0]  line_init = '0;
    logic [15:0] mask_first = '1, mask_mid = '1, mask_last = '1;
    logic [15:0] x_words = 16'd1, y_lines = 16'd1;
    logic        go = 1'b0, word_en = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0;
    logic        src_take, busy, wr_valid;
    logic [3:0]  line_num;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    blt_word_combine dut (
        .clk(clk), .rst_n(rst_n), .ht_we(ht_we), .ht_addr(ht_addr), .ht_wdata(ht_wdata),
        .hop(hop), .op(op), .skew(skew), .fxsr(fxsr), .nfsr(nfsr), .smudge(smudge),
        .line_init(line_init), .line_down(line_down), .mask_first(mask_first),
        .mask_mid(mask_mid), .mask_last(mask_last), .x_words(x_words), .y_lines(y_lines),
        .go(go), .word_en(word_en), .src_in(src_in), .dst_in(dst_in), .src_take(src_take),
        .busy(busy), .line_num(line_num), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    function automatic logic [15:0] ht_val(input int i);
        return {4'(i), 12'hA5C ^ 12'(i * 37)};
    endfunction

    function automatic logic [15:0] f_op(input logic [3:0] c, input logic [15:0] p, input logic [15:0] d);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            case ({p[i], d[i]})
                2'b11:   r[i] = c[0];
                2'b10:   r[i] = c[1];
                2'b01:   r[i] = c[2];
                default: r[i] = c[3];
            endcase
        end
        return r;
    endfunction

    function automatic logic [15:0] f_pat(input logic [1:0] h, input logic [15:0] s, input logic [15:0] t);
        case (h)
            2'd0:    return 16'hFFFF;
            2'd1:    return t;
            2'd2:    return s;
            default: return s & t;
        endcase
    endfunction

    function automatic logic [15:0] f_skew(input logic [15:0] p, input logic [15:0] c, input logic [3:0] k);
        logic [31:0] j;
        j = {p, c} >> k;
        return j[15:0];
    endfunction

    function automatic logic [15:0] f_word(input logic [15:0] s, input logic [15:0] d,
                                           input logic [3:0] ln, input logic [15:0] m);
        logic [15:0] t;
        t = ht_val(smudge ? int'(s[3:0]) : int'(ln));
        return (f_op(op, f_pat(hop, s, t), d) & m) | (d & ~m);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_blit(input int xw, input int yl);
        x_words = 16'(xw);
        y_lines = 16'(yl);
        go = 1'b1;
        @(posedge clk);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic step(input logic [15:0] s, input logic [15:0] d, input logic exp_take,
                        input logic exp_wv, input logic [15:0] exp_d, input string req);
        word_en = 1'b1;
        src_in  = s;
        dst_in  = d;
        #1;
        chk({req, " src_take"}, 16'(src_take), 16'(exp_take));
        @(posedge clk);
        @(negedge clk);
        word_en = 1'b0;
        chk({req, " wr_valid"}, 16'(wr_valid), 16'(exp_wv));
        if (exp_wv) chk({req, " wr_data"}, wr_data, exp_d);
    endtask

    task automatic set_plain();
        hop = 2'd2; op = 4'd3; skew = '0; fxsr = 0; nfsr = 0; smudge = 0;
        line_down = 0; line_init = '0;
        mask_first = '1; mask_mid = '1; mask_last = '1;
    endtask

    task automatic t_reset();
        chk("R10 busy after reset", 16'(busy), 16'd0);
        chk("R11 wr_valid after reset", 16'(wr_valid), 16'd0);
        chk("R9 line_num after reset", 16'(line_num), 16'd0);
        chk("R10 src_take after reset", 16'(src_take), 16'd0);
    endtask

    task automatic t_ht_reset_zero();
        set_plain(); hop = 2'd1; line_init = 4'd9;
        start_blit(1, 1);
        step(16'h1234, 16'h5555, 1, 1, 16'h0000, "R1 halftone zero after reset");
    endtask

    task automatic t_load_ht();
        for (int i = 0; i < 16; i++) begin
            ht_we = 1'b1; ht_addr = 4'(i); ht_wdata = ht_val(i);
            @(posedge clk);
            @(negedge clk);
        end
        ht_we = 1'b0;
    endtask

    task automatic t_ops();
        logic [15:0] s = 16'hF0CC, d = 16'hAAF0;
        set_plain();
        for (int c = 0; c < 16; c++) begin
            op = 4'(c);
            start_blit(1, 1);
            step(s, d, 1, 1, f_op(4'(c), s, d), $sformatf("R4 op=%0d", c));
        end
    endtask

    task automatic t_hop();
        logic [15:0] s = 16'h3C96, d = 16'h0F0F;
        set_plain(); line_init = 4'd5;
        for (int h = 0; h < 4; h++) begin
            hop = 2'(h);
            start_blit(1, 1);
            step(s, d, 1, 1, f_pat(2'(h), s, ht_val(5)), $sformatf("R3 hop=%0d", h));
        end
    endtask

    task automatic t_masks();
        set_plain(); op = 4'd15;
        mask_first = 16'hF00F; mask_mid = 16'h0FF0; mask_last = 16'h3C3C;
        start_blit(3, 1);
        step(16'h1111, 16'h1234, 1, 1, 16'hF23F, "R8 first mask");
        step(16'h2222, 16'h5678, 1, 1, 16'h5FF8, "R8 middle mask");
        step(16'h3333, 16'h9ABC, 1, 1, 16'hBEBC, "R8 last mask");
        start_blit(1, 1);
        step(16'h4444, 16'h0000, 1, 1, 16'hF00F, "R8 single word uses first mask");
    endtask

    task automatic t_skew_prime();
        set_plain(); skew = 4'd4; fxsr = 1; nfsr = 1;
        start_blit(3, 1);
        step(16'hA1B2, 16'h0, 1, 0, 16'h0, "R6 prime step");
        step(16'hC3D4, 16'h0, 1, 1, f_skew(16'hA1B2, 16'hC3D4, 4), "R5 skew word0");
        step(16'hE5F6, 16'h0, 1, 1, f_skew(16'hC3D4, 16'hE5F6, 4), "R5 skew word1");
        step(16'h7777, 16'h0, 0, 1, f_skew(16'hE5F6, 16'h0000, 4), "R7 final read skipped");
        chk("R10 idle after rectangle", 16'(busy), 16'd0);
        nfsr = 0;
        start_blit(1, 2);
        step(16'h1357, 16'h0, 1, 0, 16'h0, "R6 prime line0");
        step(16'h2468, 16'h0, 1, 1, f_skew(16'h1357, 16'h2468, 4), "R6 data line0");
        step(16'h9BDF, 16'h0, 1, 0, 16'h0, "R6 prime line1");
        step(16'hACE0, 16'h0, 1, 1, f_skew(16'h9BDF, 16'hACE0, 4), "R6 data line1");
    endtask

    task automatic t_skew_carry();
        set_plain(); skew = 4'd8;
        start_blit(2, 1);
        step(16'h1122, 16'h0, 1, 1, f_skew(16'h0000, 16'h1122, 8), "R5 history cleared at start");
        step(16'h3344, 16'h0, 1, 1, f_skew(16'h1122, 16'h3344, 8), "R5 history carried");
    endtask

    task automatic t_smudge();
        set_plain(); smudge = 1; hop = 2'd1; line_init = 4'd3;
        start_blit(2, 1);
        step(16'h0007, 16'h0, 1, 1, ht_val(7), "R2 smudge index 7");
        step(16'hFFF2, 16'h0, 1, 1, ht_val(2), "R2 smudge index 2");
        smudge = 0;
        start_blit(1, 1);
        step(16'h0007, 16'h0, 1, 1, ht_val(3), "R2 line index 3");
    endtask

    task automatic t_lines();
        set_plain(); hop = 2'd1; line_init = 4'd15;
        start_blit(1, 3);
        chk("R9 line loaded", 16'(line_num), 16'd15);
        step(16'h0, 16'h0, 1, 1, f_word(16'h0, 16'h0, 4'd15, 16'hFFFF), "R9 line 15");
        step(16'h0, 16'h0, 1, 1, f_word(16'h0, 16'h0, 4'd0, 16'hFFFF), "R9 wrap up to 0");
        step(16'h0, 16'h0, 1, 1, f_word(16'h0, 16'h0, 4'd1, 16'hFFFF), "R9 line 1");
        chk("R9 final line_num", 16'(line_num), 16'd2);
        line_down = 1; line_init = 4'd0;
        start_blit(1, 2);
        step(16'h0, 16'h0, 1, 1, ht_val(0), "R9 line 0 down");
        step(16'h0, 16'h0, 1, 1, ht_val(15), "R9 wrap down to 15");
        chk("R9 final line_num down", 16'(line_num), 16'd14);
    endtask

    task automatic t_ignored();
        set_plain(); line_init = 4'd6;
        start_blit(0, 3);
        chk("R10 zero width ignored", 16'(busy), 16'd0);
        start_blit(2, 0);
        chk("R10 zero height ignored", 16'(busy), 16'd0);
        step(16'hFFFF, 16'hFFFF, 0, 0, 16'h0, "R11 step in idle");
        chk("R11 line_num unchanged in idle", 16'(line_num), 16'd14);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ht_reset_zero();
        t_load_ht();
        t_ops();
        t_hop();
        t_masks();
        t_skew_prime();
        t_skew_carry();
        t_smudge();
        t_lines();
        t_ignored();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule